// File: doc/BRIEF.md
# Bulk OUT Receive Endpoint

This block is the receive side of a bulk OUT endpoint. Bytes arrive from a simplified link interface (valid, data, end-of-packet and a line-error flag standing in for CRC checking) and are stored in a small receive FIFO. A programmable maximum-packet register, written as the number of bytes to accept minus one, caps how many bytes one packet may place in the FIFO. Software lowers this register before a final short transfer.

At packet end the block sets a packet-complete flag and pulses an interrupt. The error flag, the FIFO-not-empty flag and the byte count are meaningful while packet-complete is 1. While packet-complete stays set, any new byte from the link is refused with a NAK indication and is not stored. A write-1-to-clear pulse on packet-complete clears the complete flag, the error flag and the byte count, and re-arms the endpoint. The FIFO drains one byte per pop through a byte-wide port. A DMA requester or the CPU can drive that port. A DMA request is raised while DMA is enabled and the FIFO holds data.

Top module: `bulk_out_rx`

## Requirements
- R1: After reset, sts_done, sts_err, sts_fifo_ne, dma_req, irq and rx_nak are 0, rx_count is 0 and maxp reads DEPTH-1 (15 by default).
- R2: A byte offered with rx_valid while sts_done is 0 and within the limits of R5 and R10 is stored in the FIFO. Stored bytes appear on drain_data in arrival order. rx_count counts the stored bytes of the current packet.
- R3: The clock edge that accepts a byte with rx_last=1 sets sts_done, visible the cycle after. irq is high for exactly that one cycle.
- R4: While sts_done is 1, rx_nak follows rx_valid in the same cycle. The refused byte is neither stored nor counted.
- R5: maxp holds the packet limit minus one and is loaded by a maxp_we pulse. Once rx_count equals maxp+1, further bytes of the packet are discarded and sts_err is set.
- R6: rx_err on any non-refused byte sets sts_err. A packet with no rx_err and no discarded byte completes with sts_err 0.
- R7: sts_fifo_ne is 1 exactly while the FIFO holds at least one byte. It updates one cycle after the store or pop that changes it.
- R8: dma_req equals dma_en AND sts_fifo_ne. Each drain_pop removes one byte. A drain_pop while the FIFO is empty changes nothing.
- R9: A clr_done pulse clears sts_done, sts_err and rx_count in the next cycle. After that, bytes are accepted again.
- R10: When the FIFO already holds DEPTH (16) bytes, an arriving byte is discarded and sts_err is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Link offers a byte this cycle |
| rx_data | input | DW | Offered byte |
| rx_last | input | 1 | Offered byte ends the packet |
| rx_err | input | 1 | Line error flagged with the offered byte |
| rx_nak | output | 1 | Offered byte refused (endpoint not armed) |
| maxp_we | input | 1 | Load maximum-packet register |
| maxp_wdata | input | CW | Packet limit minus one |
| maxp | output | CW | Current maximum-packet register |
| clr_done | input | 1 | Write-1-to-clear of packet-complete |
| sts_done | output | 1 | Packet complete |
| sts_err | output | 1 | Packet error |
| sts_fifo_ne | output | 1 | FIFO holds data |
| rx_count | output | CW | Bytes stored for current packet |
| irq | output | 1 | One-cycle packet-complete interrupt |
| dma_en | input | 1 | Enable DMA requests |
| dma_req | output | 1 | DMA request |
| drain_pop | input | 1 | Pop one byte (DMA acknowledge or CPU read) |
| drain_data | output | DW | Byte at FIFO head |

## Verification
rx_nak and drain_data are combinational. The bench checks them one time step after it drives the inputs, in the same cycle. Status flags, rx_count, irq, sts_fifo_ne and dma_req pass through one register. Each is due one cycle after the edge that captures the byte, pop or clear. The bench drives every input on a falling edge and samples at the next falling edge, half a cycle after that register is loaded. The one-cycle width of irq is checked by sampling again one falling edge later.

// File: rtl/bor_pkg.sv
package bor_pkg;

    // Decision taken for a byte offered on the link side
    typedef enum logic [1:0] {
        ACT_IDLE   = 2'd0,
        ACT_STORE  = 2'd1,
        ACT_REFUSE = 2'd2,
        ACT_DROP   = 2'd3
    } rx_act_e;

endpackage

// File: rtl/bor_fifo.sv
module bor_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [DW-1:0]              wdata,
    input  logic                       pop,
    output logic [DW-1:0]              rdata,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wp;
        logic [AW-1:0]            rp;
        logic [LW-1:0]            lvl;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.lvl != FULL_LVL);
        do_pop  = pop && (st_q.lvl != '0);
        if (do_push) begin
            st_d.mem[st_q.wp] = wdata;
            st_d.wp           = bump(st_q.wp);
        end
        if (do_pop) begin
            st_d.rp = bump(st_q.rp);
        end
        case ({do_push, do_pop})
            2'b10:   st_d.lvl = st_q.lvl + 1'b1;
            2'b01:   st_d.lvl = st_q.lvl - 1'b1;
            default: st_d.lvl = st_q.lvl;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.mem[st_q.rp];
    assign empty = (st_q.lvl == '0);
    assign full  = (st_q.lvl == FULL_LVL);
    assign level = st_q.lvl;

endmodule

// File: rtl/bor_ctrl.sv
module bor_ctrl
    import bor_pkg::*;
#(
    parameter int DW       = 8,
    parameter int CW       = 8,
    parameter int MAXP_RST = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_last,
    input  logic          rx_err,
    input  logic          maxp_we,
    input  logic [CW-1:0] maxp_wdata,
    input  logic          clr_done,
    input  logic          fifo_full,
    output logic          push,
    output logic [DW-1:0] push_data,
    output logic          nak,
    output logic          done,
    output logic          err,
    output logic          irq,
    output logic [CW-1:0] count,
    output logic [CW-1:0] maxp
);
    // One extra count bit so a full 2**CW packet does not wrap the limit test
    typedef struct packed {
        logic          done;
        logic          err;
        logic          irq;
        logic [CW:0]   cnt;
        logic [CW-1:0] maxp;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    rx_act_e  act;

    always_comb begin
        act = ACT_IDLE;
        if (rx_valid) begin
            if (st_q.done) begin
                act = ACT_REFUSE;
            end else if ((st_q.cnt > {1'b0, st_q.maxp}) || fifo_full) begin
                act = ACT_DROP;
            end else begin
                act = ACT_STORE;
            end
        end

        st_d     = st_q;
        st_d.irq = 1'b0;

        if (maxp_we) begin
            st_d.maxp = maxp_wdata;
        end

        case (act)
            ACT_STORE: st_d.cnt = st_q.cnt + 1'b1;
            ACT_DROP:  st_d.err = 1'b1;
            default:   ;
        endcase

        if ((act == ACT_STORE) || (act == ACT_DROP)) begin
            if (rx_err) begin
                st_d.err = 1'b1;
            end
            if (rx_last) begin
                st_d.done = 1'b1;
                st_d.irq  = 1'b1;
            end
        end

        if (clr_done) begin
            st_d.done = 1'b0;
            st_d.err  = 1'b0;
            st_d.irq  = 1'b0;
            st_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.maxp <= CW'(MAXP_RST);
        end else begin
            st_q <= st_d;
        end
    end

    assign push      = (act == ACT_STORE);
    assign push_data = rx_data;
    assign nak       = (act == ACT_REFUSE);
    assign done      = st_q.done;
    assign err       = st_q.err;
    assign irq       = st_q.irq;
    assign count     = st_q.cnt[CW-1:0];
    assign maxp      = st_q.maxp;

endmodule

// File: rtl/bulk_out_rx.sv
module bulk_out_rx #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int CW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_last,
    input  logic          rx_err,
    output logic          rx_nak,
    input  logic          maxp_we,
    input  logic [CW-1:0] maxp_wdata,
    output logic [CW-1:0] maxp,
    input  logic          clr_done,
    output logic          sts_done,
    output logic          sts_err,
    output logic          sts_fifo_ne,
    output logic [CW-1:0] rx_count,
    output logic          irq,
    input  logic          dma_en,
    output logic          dma_req,
    input  logic          drain_pop,
    output logic [DW-1:0] drain_data
);
    localparam int LW = $clog2(DEPTH + 1);

    logic          fifo_push;
    logic [DW-1:0] fifo_wdata;
    logic          fifo_empty;
    logic          fifo_full;
    logic [LW-1:0] fifo_level;

    bor_ctrl #(
        .DW       (DW),
        .CW       (CW),
        .MAXP_RST (DEPTH - 1)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_last    (rx_last),
        .rx_err     (rx_err),
        .maxp_we    (maxp_we),
        .maxp_wdata (maxp_wdata),
        .clr_done   (clr_done),
        .fifo_full  (fifo_full),
        .push       (fifo_push),
        .push_data  (fifo_wdata),
        .nak        (rx_nak),
        .done       (sts_done),
        .err        (sts_err),
        .irq        (irq),
        .count      (rx_count),
        .maxp       (maxp)
    );

    bor_fifo #(
        .DW    (DW),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .wdata (fifo_wdata),
        .pop   (drain_pop),
        .rdata (drain_data),
        .empty (fifo_empty),
        .full  (fifo_full),
        .level (fifo_level)
    );

    assign sts_fifo_ne = !fifo_empty;
    assign dma_req     = dma_en && !fifo_empty;

endmodule

// File: rtl/bor_chk.sv
module bor_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       rx_valid,
    input logic                       rx_nak,
    input logic                       sts_done,
    input logic                       sts_err,
    input logic                       sts_fifo_ne,
    input logic                       irq,
    input logic                       clr_done,
    input logic                       drain_pop,
    input logic [CW-1:0]              rx_count,
    input logic [CW-1:0]              maxp,
    input logic                       fifo_push,
    input logic                       fifo_full,
    input logic [$clog2(DEPTH+1)-1:0] fifo_level
);
    AST_NAK_WHILE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && sts_done) |-> rx_nak); // R4

    AST_NO_STORE_WHILE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        sts_done |-> !fifo_push); // R4

    AST_IRQ_MARKS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $rose(sts_done)); // R3

    AST_STORE_WITHIN_MAXP: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> (rx_count <= maxp)); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_push); // R10

    AST_POP_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_pop && !fifo_push && fifo_level != '0) |=>
        (fifo_level == $past(fifo_level) - 1'b1)); // R8

    AST_NE_MATCHES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        sts_fifo_ne == (fifo_level != '0)); // R7

    AST_CLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_done |=> (!sts_done && !sts_err && rx_count == '0)); // R9

endmodule

bind bulk_out_rx bor_chk #(
    .DEPTH (DEPTH),
    .CW    (CW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .rx_nak      (rx_nak),
    .sts_done    (sts_done),
    .sts_err     (sts_err),
    .sts_fifo_ne (sts_fifo_ne),
    .irq         (irq),
    .clr_done    (clr_done),
    .drain_pop   (drain_pop),
    .rx_count    (rx_count),
    .maxp        (maxp),
    .fifo_push   (fifo_push),
    .fifo_full   (fifo_full),
    .fifo_level  (fifo_level)
);

// File: tb/bulk_out_rx_tb.sv
module bulk_out_rx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_last = 1'b0;
    logic       rx_err = 1'b0;
    logic       rx_nak;
    logic       maxp_we = 1'b0;
    logic [7:0] maxp_wdata = '0;
    logic [7:0] maxp;
    logic       clr_done = 1'b0;
    logic       sts_done, sts_err, sts_fifo_ne, irq, dma_req;
    logic [7:0] rx_count;
    logic       dma_en = 1'b0;
    logic       drain_pop = 1'b0;
    logic [7:0] drain_data;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bulk_out_rx u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .rx_err(rx_err), .rx_nak(rx_nak),
        .maxp_we(maxp_we), .maxp_wdata(maxp_wdata), .maxp(maxp),
        .clr_done(clr_done), .sts_done(sts_done), .sts_err(sts_err),
        .sts_fifo_ne(sts_fifo_ne), .rx_count(rx_count), .irq(irq),
        .dma_en(dma_en), .dma_req(dma_req), .drain_pop(drain_pop),
        .drain_data(drain_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic send_byte(input logic [7:0] d, input logic last, input logic e);
        rx_valid = 1'b1; rx_data = d; rx_last = last; rx_err = e;
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
    endtask

    task automatic pop_expect(input string tag, input logic [7:0] exp);
        chk(tag, drain_data, exp);
        drain_pop = 1'b1;
        @(negedge clk);
        drain_pop = 1'b0;
    endtask

    task automatic clear_done();
        clr_done = 1'b1;
        @(negedge clk);
        clr_done = 1'b0;
    endtask

    task automatic set_maxp(input logic [7:0] v);
        maxp_we = 1'b1; maxp_wdata = v;
        @(negedge clk);
        maxp_we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 done", sts_done, 0);
        chk("R1 err", sts_err, 0);
        chk("R1 fifo_ne", sts_fifo_ne, 0);
        chk("R1 dma_req", dma_req, 0);
        chk("R1 irq", irq, 0);
        chk("R1 nak", rx_nak, 0);
        chk("R1 count", rx_count, 0);
        chk("R1 maxp", maxp, 15);
    endtask

    task automatic t_basic();
        rx_valid = 1'b1; rx_data = 8'hA0; #1;
        chk("R4 no nak while armed", rx_nak, 0);
        @(negedge clk);
        rx_valid = 1'b0;
        chk("R7 fifo_ne after first byte", sts_fifo_ne, 1);
        for (int i = 1; i < 4; i++) send_byte(8'hA0 + 8'(i), i == 3, 1'b0);
        chk("R3 done set", sts_done, 1);
        chk("R3 irq pulse", irq, 1);
        chk("R6 clean err", sts_err, 0);
        chk("R2 count", rx_count, 4);
        chk("R8 dma_req off", dma_req, 0);
        dma_en = 1'b1;
        @(negedge clk);
        chk("R3 irq one cycle", irq, 0);
        chk("R8 dma_req on", dma_req, 1);
        for (int i = 0; i < 4; i++) pop_expect("R2 order", 8'hA0 + 8'(i));
        chk("R7 fifo_ne drained", sts_fifo_ne, 0);
        chk("R8 dma_req drained", dma_req, 0);
        dma_en = 1'b0;
        clear_done();
        chk("R9 done cleared", sts_done, 0);
        chk("R9 count cleared", rx_count, 0);
    endtask

    task automatic t_nak();
        send_byte(8'h11, 1'b0, 1'b0);
        send_byte(8'h22, 1'b1, 1'b0);
        rx_valid = 1'b1; rx_data = 8'h99; #1;
        chk("R4 nak", rx_nak, 1);
        @(negedge clk);
        rx_valid = 1'b0;
        chk("R4 count unchanged", rx_count, 2);
        pop_expect("R4 data0", 8'h11);
        pop_expect("R4 data1", 8'h22);
        chk("R4 refused byte absent", sts_fifo_ne, 0);
        clear_done();
    endtask

    task automatic t_maxp();
        set_maxp(8'd2);
        chk("R5 maxp loaded", maxp, 2);
        for (int i = 0; i < 5; i++) send_byte(8'h30 + 8'(i), i == 4, 1'b0);
        chk("R5 count capped", rx_count, 3);
        chk("R5 err", sts_err, 1);
        chk("R5 done", sts_done, 1);
        for (int i = 0; i < 3; i++) pop_expect("R5 data", 8'h30 + 8'(i));
        chk("R5 extra discarded", sts_fifo_ne, 0);
        clear_done();
        chk("R9 err cleared", sts_err, 0);
        set_maxp(8'd15);
    endtask

    task automatic t_err();
        send_byte(8'h55, 1'b0, 1'b0);
        send_byte(8'h66, 1'b1, 1'b1);
        chk("R6 err flagged", sts_err, 1);
        chk("R6 count", rx_count, 2);
        pop_expect("R6 data0", 8'h55);
        pop_expect("R6 data1", 8'h66);
        clear_done();
        send_byte(8'h12, 1'b1, 1'b0);
        chk("R9 rearmed", sts_done, 1);
        chk("R9 err clear after rearm", sts_err, 0);
        pop_expect("R9 data", 8'h12);
        clear_done();
    endtask

    task automatic t_full();
        set_maxp(8'd31);
        for (int i = 0; i < 17; i++) send_byte(8'h40 + 8'(i), i == 16, 1'b0);
        chk("R10 count", rx_count, 16);
        chk("R10 err", sts_err, 1);
        chk("R8 dma disabled", dma_req, 0);
        for (int i = 0; i < 16; i++) pop_expect("R10 data", 8'h40 + 8'(i));
        chk("R10 empty", sts_fifo_ne, 0);
        drain_pop = 1'b1;
        @(negedge clk);
        drain_pop = 1'b0;
        chk("R8 pop on empty", sts_fifo_ne, 0);
        clear_done();
        set_maxp(8'd15);
        send_byte(8'h77, 1'b1, 1'b0);
        chk("R8 level after empty pop", sts_fifo_ne, 1);
        pop_expect("R8 head after empty pop", 8'h77);
        chk("R8 empty again", sts_fifo_ne, 0);
        clear_done();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_nak();
        t_maxp();
        t_err();
        t_full();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule